// File: doc/BRIEF.md
# Priority Transmit Buffer Arbiter

This block picks which of several armed CAN transmit buffers goes next to the frame transmitter. It needs no CPU to do this. Software loads an identifier and a format flag into a buffer and arms it, all in one write. The block then ranks every armed buffer in the order that bus arbitration would settle them, so a high-priority frame never waits behind a low-priority one. Standard 11-bit and extended 29-bit identifiers can be armed at the same time, and they are compared against each other.

Frames whose identifiers are equal leave in the order their buffers were armed. Each buffer's place in that order is tracked with pairwise older-than flags, not with a fixed buffer index. Toward the transmitter, the block raises a request and shows the chosen buffer's index, identifier and format. When the transmitter accepts, the choice is frozen. It stays frozen until the transmitter reports success, lost arbitration or an error. Only success disarms the buffer. A buffer that lost keeps both its contents and its place in the arming order.

Top module: `tx_prio_arb`

## Requirements
- R1: After reset no buffer is armed, `req_o` is low and `sel_idx_o` is 0.
- R2: A pulse on `arm_i[b]` loads `wr_id_i`/`wr_ext_i` slice b and arms buffer b, but only if b is not armed. Arming an already armed buffer is ignored and leaves its identifier unchanged. When `clr_i[b]` and `arm_i[b]` are both high in the same cycle, the clear wins.
- R3: A standard frame (`wr_ext_i[b]`=0) uses id bits [10:0] as its identifier, and bits [28:11] are ignored. An extended frame (`wr_ext_i[b]`=1) uses bits [28:18] as its base part and bits [17:0] as its extension. `sel_id_o`/`sel_ext_o` show the stored identifier and format of the selected buffer.
- R4: Among armed buffers, the one whose 11-bit base part is numerically lowest is selected.
- R5: When base parts are equal, a standard frame beats an extended one. Between two extended frames, the lower 18-bit extension wins.
- R6: Among equal identifiers of the same format, the buffer armed earliest is selected. Buffers armed in the same cycle rank by ascending index.
- R7: `req_o` is high exactly when no transfer is in progress and at least one buffer is armed. An arm or clear takes effect in the selection from the next cycle. A clear of an idle armed buffer removes it.
- R8: `tx_start_i` while `req_o` is high starts a transfer. From then until `tx_done_i` or `tx_abort_i`, `sel_idx_o` is frozen and `req_o` is low. A clear aimed at the granted buffer during the transfer is ignored.
- R9: `tx_done_i` during a transfer disarms the granted buffer. `tx_abort_i` alone ends the transfer, and the buffer stays armed with its place in the arming order. If both arrive in the same cycle, `tx_done_i` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | NUM_BUF | Per-buffer arm pulse |
| clr_i | input | NUM_BUF | Per-buffer clear pulse |
| wr_id_i | input | NUM_BUF*29 | Identifier per buffer, captured on arm |
| wr_ext_i | input | NUM_BUF | Extended-format flag per buffer, captured on arm |
| tx_start_i | input | 1 | Transmitter accepts the offered buffer |
| tx_done_i | input | 1 | Transfer completed successfully |
| tx_abort_i | input | 1 | Arbitration lost or error; retry later |
| req_o | output | 1 | A buffer is offered to the transmitter |
| sel_idx_o | output | $clog2(NUM_BUF) | Index of the selected buffer |
| sel_id_o | output | 29 | Stored identifier of the selected buffer |
| sel_ext_o | output | 1 | Format of the selected buffer |

## Verification
The bench builds the block with NUM_BUF=4. With four buffers, one vector can drain a complete ranking, and that ranking mixes base-part wins, standard-over-extended wins and extension-bit wins. Four buffers also allow three equal identifiers to be armed in the same cycle behind one that was armed earlier, which covers both the index tie rule and the age tie rule. The directed part then runs grant freezing, clearing the granted buffer, abort keeping a buffer's age, done overriding abort, and re-arming an already armed buffer.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  localparam int ID_W   = 29;
  localparam int BASE_W = 11;
  localparam int EXT_W  = ID_W - BASE_W;
  localparam int KEY_W  = BASE_W + 1 + EXT_W;
  typedef logic [KEY_W-1:0] key_t;
endpackage

// File: rtl/tx_key_fmt.sv
// Map an identifier to an arbitration-order key: lower key wins on the bus.
module tx_key_fmt
  import tx_arb_pkg::*;
(
  input  logic [ID_W-1:0] id_i,
  input  logic            ext_i,
  output key_t            key_o
);
  always_comb begin
    if (ext_i) key_o = {id_i[ID_W-1 -: BASE_W], 1'b1, id_i[EXT_W-1:0]};
    else       key_o = {id_i[BASE_W-1:0], 1'b0, {EXT_W{1'b0}}};
  end
endmodule

// File: rtl/tx_age_matrix.sv
// older_o[r*N+c] set: buffer r was armed before buffer c.
module tx_age_matrix #(
  parameter int N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   arm_i,
  input  logic [N-1:0]   live_i,
  output logic [N*N-1:0] older_o
);
  logic [N*N-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          if (r != c) begin
            if (arm_i[r] && arm_i[c]) older_q[r*N+c] <= (r < c);
            else if (arm_i[r])        older_q[r*N+c] <= 1'b0;
            else if (arm_i[c])        older_q[r*N+c] <= 1'b1;
          end
        end
      end
    end
  end

  assign older_o = older_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = i + 1; j < N; j++) begin : g_col
      assert_order_total_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_i[i] && live_i[j]) |-> (older_q[i*N+j] != older_q[j*N+i]));
    end
  end
endmodule

// File: rtl/tx_win_sel.sv
module tx_win_sel
  import tx_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]       live_i,
  input  logic [N*KEY_W-1:0] keys_i,
  input  logic [N*N-1:0]     older_i,
  output logic [N-1:0]       win_o,
  output logic [IDX_W-1:0]   idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_cand
    logic beats;
    always_comb begin
      beats = live_i[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && live_i[j]) begin
          if (!((keys_i[i*KEY_W +: KEY_W] < keys_i[j*KEY_W +: KEY_W]) ||
                ((keys_i[i*KEY_W +: KEY_W] == keys_i[j*KEY_W +: KEY_W]) && older_i[i*N+j])))
            beats = 1'b0;
        end
      end
    end
    assign win_o[i] = beats;
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (win_o[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/tx_prio_arb.sv
module tx_prio_arb
  import tx_arb_pkg::*;
#(
  parameter int NUM_BUF = 4,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_BUF-1:0]      arm_i,
  input  logic [NUM_BUF-1:0]      clr_i,
  input  logic [NUM_BUF*ID_W-1:0] wr_id_i,
  input  logic [NUM_BUF-1:0]      wr_ext_i,
  input  logic                    tx_start_i,
  input  logic                    tx_done_i,
  input  logic                    tx_abort_i,
  output logic                    req_o,
  output logic [IDX_W-1:0]        sel_idx_o,
  output logic [ID_W-1:0]         sel_id_o,
  output logic                    sel_ext_o
);
  logic [NUM_BUF-1:0]         armed_q;
  logic [ID_W-1:0]            id_q [NUM_BUF];
  logic [NUM_BUF-1:0]         ext_q;
  logic                       busy_q;
  logic [IDX_W-1:0]           lock_q;
  logic [NUM_BUF*KEY_W-1:0]   keys_w;
  logic [NUM_BUF*NUM_BUF-1:0] older_w;
  logic [NUM_BUF-1:0]         win_w;
  logic [IDX_W-1:0]           win_idx;
  logic [NUM_BUF-1:0]         arm_eff, clr_eff, lock_oh, done_mask;
  logic                       done_ev, abort_ev, grant_ev;

  assign done_ev  = busy_q && tx_done_i;
  assign abort_ev = busy_q && tx_abort_i && !tx_done_i;
  assign req_o    = !busy_q && (|armed_q);
  assign grant_ev = tx_start_i && req_o;

  always_comb begin
    lock_oh = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (lock_q == IDX_W'(i)) lock_oh[i] = 1'b1;
  end

  assign arm_eff   = arm_i & ~armed_q & ~clr_i;
  assign clr_eff   = clr_i & ~(busy_q ? lock_oh : '0);
  assign done_mask = done_ev ? lock_oh : '0;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[b]  <= '0;
        ext_q[b] <= 1'b0;
      end else if (arm_eff[b]) begin
        id_q[b]  <= wr_id_i[b*ID_W +: ID_W];
        ext_q[b] <= wr_ext_i[b];
      end
    end

    tx_key_fmt u_key (
      .id_i  (id_q[b]),
      .ext_i (ext_q[b]),
      .key_o (keys_w[b*KEY_W +: KEY_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= '0;
      busy_q  <= 1'b0;
      lock_q  <= '0;
    end else begin
      armed_q <= (armed_q | arm_eff) & ~clr_eff & ~done_mask;
      if (done_ev || abort_ev) begin
        busy_q <= 1'b0;
      end else if (grant_ev) begin
        busy_q <= 1'b1;
        lock_q <= win_idx;
      end
    end
  end

  tx_age_matrix #(.N(NUM_BUF)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_eff),
    .live_i  (armed_q),
    .older_o (older_w)
  );

  tx_win_sel #(.N(NUM_BUF), .IDX_W(IDX_W)) u_sel (
    .live_i  (armed_q),
    .keys_i  (keys_w),
    .older_i (older_w),
    .win_o   (win_w),
    .idx_o   (win_idx)
  );

  assign sel_idx_o = busy_q ? lock_q : win_idx;
  assign sel_id_o  = id_q[sel_idx_o];
  assign sel_ext_o = ext_q[sel_idx_o];

  // Independent check: no armed buffer outranks the offered one.
  logic min_ok;
  always_comb begin
    min_ok = armed_q[win_idx];
    for (int j = 0; j < NUM_BUF; j++) begin
      if (armed_q[j] && IDX_W'(j) != win_idx) begin
        if (keys_w[j*KEY_W +: KEY_W] < keys_w[win_idx*KEY_W +: KEY_W]) min_ok = 1'b0;
        if (keys_w[j*KEY_W +: KEY_W] == keys_w[win_idx*KEY_W +: KEY_W] &&
            older_w[j*NUM_BUF + int'(win_idx)]) min_ok = 1'b0;
      end
    end
  end

  assert_min_key_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> min_ok);

  assert_grant_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_ev |=> (!req_o && sel_idx_o == $past(sel_idx_o)));

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tx_done_i && !tx_abort_i) |=> (sel_idx_o == $past(sel_idx_o)));

  assert_done_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tx_done_i) |=> !armed_q[$past(lock_q)]);

  assert_abort_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tx_abort_i && !tx_done_i) |=> armed_q[$past(lock_q)]);
endmodule

// File: tb/tx_prio_arb_tb_top.sv
`timescale 1ns/1ps
module tx_prio_arb_tb_top;
  localparam int NB = 4;
  localparam int IW = 29;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NB-1:0] arm_i = '0, clr_i = '0, wr_ext_i = '0;
  logic [NB*IW-1:0] wr_id_i = '0;
  logic          tx_start_i = 1'b0, tx_done_i = 1'b0, tx_abort_i = 1'b0;
  logic          req_o, sel_ext_o;
  logic [1:0]    sel_idx_o;
  logic [IW-1:0] sel_id_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  tx_prio_arb #(.NUM_BUF(NB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .clr_i(clr_i),
    .wr_id_i(wr_id_i), .wr_ext_i(wr_ext_i), .tx_start_i(tx_start_i),
    .tx_done_i(tx_done_i), .tx_abort_i(tx_abort_i), .req_o(req_o),
    .sel_idx_o(sel_idx_o), .sel_id_o(sel_id_o), .sel_ext_o(sel_ext_o)
  );

  typedef struct packed {
    logic [3:0][28:0] id;
    logic [3:0]       ext;
    logic [3:0]       m1;
    logic [3:0]       m2;
    logic [3:0][1:0]  ord;
  } vec_t;

  // id/ext/ord listed buffer 3 first; ord[0] is the first expected pick.
  localparam vec_t VECS [4] = '{
    '{id:'{29'h050, 29'h200, 29'h100, 29'h1FFFF300}, ext:4'b0000,
      m1:4'b1111, m2:4'b0000, ord:'{2'd0, 2'd2, 2'd1, 2'd3}},
    '{id:'{29'h4000004, 29'h3FFFFFF, 29'h100, 29'h4000005}, ext:4'b1101,
      m1:4'b1111, m2:4'b0000, ord:'{2'd0, 2'd3, 2'd1, 2'd2}},
    '{id:'{29'h123, 29'h123, 29'h123, 29'h123}, ext:4'b0000,
      m1:4'b0100, m2:4'b1011, ord:'{2'd3, 2'd1, 2'd0, 2'd2}},
    '{id:'{29'h1ABCDEF, 29'h000, 29'h1ABCDEF, 29'h7FF}, ext:4'b1010,
      m1:4'b1000, m2:4'b0111, ord:'{2'd0, 2'd1, 2'd3, 2'd2}}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic set_buf(input int b, input logic [28:0] id, input bit ext);
    wr_id_i[b*IW +: IW] = id;
    wr_ext_i[b] = ext;
  endtask

  task automatic start_tx();
    tx_start_i = 1'b1; step(); tx_start_i = 1'b0;
  endtask

  task automatic finish_tx();
    tx_done_i = 1'b1; step(); tx_done_i = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_o == 1'b0, "R1", "req after reset", 32'(req_o), 0);
    chk(sel_idx_o == 2'd0, "R1", "idx after reset", 32'(sel_idx_o), 0);
    rst_ni = 1'b1;
    step();
    chk(req_o == 1'b0, "R1", "req idle", 32'(req_o), 0);

    // Vector walk: R3 R4 R5 R6 ranking and drain order
    for (int v = 0; v < 4; v++) begin
      for (int b = 0; b < NB; b++) set_buf(b, VECS[v].id[b], VECS[v].ext[b]);
      arm_i = VECS[v].m1; step();
      arm_i = VECS[v].m2; step();
      arm_i = '0;
      for (int k = 0; k < NB; k++) begin
        chk(req_o == 1'b1, "R7", $sformatf("v%0d req k%0d", v, k), 32'(req_o), 1);
        chk(sel_idx_o == VECS[v].ord[k], "R4", $sformatf("v%0d pick k%0d", v, k),
            32'(sel_idx_o), 32'(VECS[v].ord[k]));
        if (v == 1 && k == 0) begin
          chk(sel_id_o == 29'h3FFFFFF && sel_ext_o == 1'b1, "R3", "v1 sel id",
              32'(sel_id_o), 32'h3FFFFFF);
        end
        start_tx();
        finish_tx();
      end
      chk(req_o == 1'b0, "R9", $sformatf("v%0d drained", v), 32'(req_o), 0);
    end

    // R2: re-arm of armed buffer ignored
    set_buf(0, 29'd9, 1'b0);
    arm_i = 4'b0001; step();
    set_buf(0, 29'd1, 1'b0);
    set_buf(1, 29'd5, 1'b0);
    arm_i = 4'b0011; step(); arm_i = '0;
    chk(sel_idx_o == 2'd1, "R2", "rearm ignored idx", 32'(sel_idx_o), 1);
    // R2: clear wins over arm in the same cycle
    set_buf(3, 29'd0, 1'b0);
    arm_i = 4'b1000; clr_i = 4'b1000; step(); arm_i = '0; clr_i = '0;
    chk(sel_idx_o == 2'd1, "R2", "clear beats arm", 32'(sel_idx_o), 1);

    // R8: freeze during transfer
    start_tx();
    set_buf(2, 29'd0, 1'b0);
    arm_i = 4'b0100; clr_i = 4'b0010; step(); arm_i = '0; clr_i = '0;
    chk(sel_idx_o == 2'd1, "R8", "frozen idx", 32'(sel_idx_o), 1);
    chk(req_o == 1'b0, "R8", "req low busy", 32'(req_o), 0);
    tx_abort_i = 1'b1; step(); tx_abort_i = 1'b0;
    chk(req_o == 1'b1, "R9", "req after abort", 32'(req_o), 1);
    chk(sel_idx_o == 2'd2, "R4", "new lowest after abort", 32'(sel_idx_o), 2);
    chk(sel_id_o == 29'd0, "R3", "sel id b2", 32'(sel_id_o), 0);
    start_tx(); finish_tx();
    chk(sel_idx_o == 2'd1, "R8", "granted clear ignored", 32'(sel_idx_o), 1);

    // R9: aborted buffer keeps its age against a later equal id
    set_buf(3, 29'd5, 1'b0);
    arm_i = 4'b1000; step(); arm_i = '0;
    chk(sel_idx_o == 2'd1, "R9", "abort keeps age", 32'(sel_idx_o), 1);
    start_tx();
    tx_done_i = 1'b1; tx_abort_i = 1'b1; step(); tx_done_i = 1'b0; tx_abort_i = 1'b0;
    chk(sel_idx_o == 2'd3, "R9", "done beats abort", 32'(sel_idx_o), 3);
    start_tx(); finish_tx();
    chk(sel_idx_o == 2'd0, "R9", "last remaining", 32'(sel_idx_o), 0);
    chk(sel_id_o == 29'd9, "R2", "b0 id kept", 32'(sel_id_o), 9);

    // R7: idle clear removes buffer
    clr_i = 4'b0001; step(); clr_i = '0;
    chk(req_o == 1'b0, "R7", "idle clear", 32'(req_o), 0);

    // R7: start with nothing armed is ignored
    start_tx();
    set_buf(2, 29'h7, 1'b0);
    arm_i = 4'b0100; step(); arm_i = '0;
    chk(req_o == 1'b1 && sel_idx_o == 2'd2, "R7", "stray start ignored", 32'(req_o), 1);
    start_tx(); finish_tx();

    summary();
  end
endmodule